// File: doc/BRIEF.md
# Staged Digital Upconverter

This block shifts baseband IQ samples onto a numerically controlled carrier, for a set of IQ channel pairs that share one clock. Every clock cycle each pair takes one signed I and one signed Q sample. It rotates that sample by the current carrier phase and delivers a 16-bit I and Q word towards the DAC. The carrier phase comes from a phase accumulator advanced by a frequency tuning word, plus a phase offset.

Software writes its settings into staging registers through a small write port. The settings are a tuning word, a phase offset and a control word for each pair. Staged values have no effect until a single update strobe. The strobe moves the staged values of every pair into the working registers on the same clock edge, so all carriers retune in lockstep. The control word can hold the accumulator at zero, or zero it for one cycle only. It can also route a fixed 32-bit IQ test word to the output in place of the mixed data. The test word is written directly, without staging.

Top module: `staged_duc`

## Requirements
- R1: While reset is low, and after reset with no writes made, every register is zero. The outputs are then zero in reset, and with the tuning word, phase offset and control word all zero they pass the input as a phase-zero rotation.
- R2: Writes with `wr_en` high go to the pair named by `wr_pair`. The `wr_addr` field selects the target. Code 0 is the 32-bit tuning word. Code 1 is the phase offset in `wr_data[15:0]`. Code 2 is the control word: bit 0 holds the clear, bit 1 is clear-once and bit 2 is output select. Code 3 is the test word, with I in `wr_data[31:16]` and Q in `wr_data[15:0]`.
- R3: Tuning word, phase offset and control writes change the outputs only after a later `upd_stb` pulse.
- R4: One `upd_stb` cycle moves the staged settings of all pairs into their working registers on the same clock edge.
- R5: Each cycle the accumulator adds the working tuning word. The phase is the top 16 accumulator bits plus the phase offset. The coefficient lookup uses the top 8 bits of that phase.
- R6: Phase 0x0000 gives cos=+32767 and sin=0. Phase 0x4000 gives cos=0 and sin=+32767. Phase 0x8000 gives cos=-32767 and sin=0. Phase 0xC000 gives cos=0 and sin=-32767. At phase 0x2000, cos equals sin and both exceed 16384.
- R7: The output I is (I·cos − Q·sin + 16384) >> 15 and the output Q is (I·sin + Q·cos + 16384) >> 15, both shifted arithmetically.
- R8: A result above 32767 is output as 32767, and a result below -32768 is output as -32768.
- R9: While the clear-hold control bit is active, the accumulator stays at zero, so the phase equals the phase offset.
- R10: An update with clear-once set zeroes the accumulator for exactly one cycle. The bit then clears itself in the working register, and the accumulation resumes.
- R11: With the working select bit set, the pair outputs its test word. A test word write reaches the output one edge after the write edge.
- R12: An input sample appears, mixed, at the output after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write enable |
| wr_pair | input | 1 | Target pair of the write (NPAIR>1 ? clog2(NPAIR) : 1) |
| wr_addr | input | 2 | Register select code |
| wr_data | input | 32 | Write data |
| upd_stb | input | 1 | Common update strobe, staging to working |
| bb_i | input | 32 | Baseband I, 16 bits per pair, pair 0 lowest |
| bb_q | input | 32 | Baseband Q, 16 bits per pair, pair 0 lowest |
| dac_i | output | 32 | Output I, 16 bits per pair |
| dac_q | output | 32 | Output Q, 16 bits per pair |

## Verification
A wrong accumulator value shows up two edges later as a rotation by the wrong quadrant. With a quarter-turn tuning word, a clear-once that is missed or repeated moves the whole output sequence by one cycle, and that shift is seen at once. A working register loaded early or late, or loaded for only one pair, changes the output on the first sample after the strobe. A select path or saturation fault shows within two edges as a wrong output word.

// File: rtl/duc_pkg.sv
package duc_pkg;
   typedef enum logic [1:0] {
      REG_FTW  = 2'd0,
      REG_POW  = 2'd1,
      REG_CTRL = 2'd2,
      REG_TEST = 2'd3
   } duc_reg_e;

   // bit 2 select, bit 1 clear-once, bit 0 clear-hold
   typedef struct packed {
      logic sel;
      logic once;
      logic hold;
   } duc_ctrl_t;
endpackage

// File: rtl/duc_regs.sv
module duc_regs
   import duc_pkg::*;
#(
   parameter int FTW_W = 32,
   parameter int POW_W = 16,
   parameter int DW    = 16,
   parameter int WD    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  duc_reg_e         wr_addr,
   input  logic [WD-1:0]    wr_data,
   input  logic             upd_stb,
   output logic [FTW_W-1:0] act_ftw,
   output logic [POW_W-1:0] act_pow,
   output duc_ctrl_t        act_ctrl,
   output logic [DW-1:0]    test_i,
   output logic [DW-1:0]    test_q
);
   logic [FTW_W-1:0] stg_ftw;
   logic [POW_W-1:0] stg_pow;
   duc_ctrl_t        stg_ctrl;

   // staging side, test word bypasses staging
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_ftw  <= '0;
         stg_pow  <= '0;
         stg_ctrl <= '0;
         test_i   <= '0;
         test_q   <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            REG_FTW:  stg_ftw  <= wr_data[FTW_W-1:0];
            REG_POW:  stg_pow  <= wr_data[POW_W-1:0];
            REG_CTRL: stg_ctrl <= duc_ctrl_t'(wr_data[2:0]);
            REG_TEST: begin
               test_i <= wr_data[2*DW-1:DW];
               test_q <= wr_data[DW-1:0];
            end
            default: ;
         endcase
      end
   end

   // working side, clear-once lives for a single cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_ftw  <= '0;
         act_pow  <= '0;
         act_ctrl <= '0;
      end else begin
         act_ctrl.once <= 1'b0;
         if (upd_stb) begin
            act_ftw  <= stg_ftw;
            act_pow  <= stg_pow;
            act_ctrl <= stg_ctrl;
         end
      end
   end
endmodule

// File: rtl/duc_nco.sv
module duc_nco #(
   parameter int FTW_W  = 32,
   parameter int POW_W  = 16,
   parameter int DW     = 16,
   parameter int LUT_AW = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [FTW_W-1:0]     ftw,
   input  logic [POW_W-1:0]     pow,
   input  logic                 clr,
   output logic [POW_W-1:0]     acc_top,
   output logic signed [DW-1:0] cos_c,
   output logic signed [DW-1:0] sin_c
);
   localparam int     N       = 2 ** LUT_AW;
   localparam int     HALF    = N / 2;
   localparam int     QUARTER = N / 4;
   localparam longint AMP_L   = (longint'(1) <<< (DW - 1)) - 1;

   typedef logic signed [DW-1:0] coef_t;

   if (LUT_AW < 3 || LUT_AW > POW_W) begin : g_bad_aw
      $error("duc_nco: LUT_AW out of range");
   end

   // rational sine fit, exact at multiples of a quarter turn
   function automatic coef_t sin_val(input int k);
      longint n, u, v;
      n = (k < HALF) ? longint'(k) : longint'(k - HALF);
      u = n * (longint'(HALF) - n);
      v = (16 * u * AMP_L) / (5 * longint'(HALF) * longint'(HALF) - 4 * u);
      return (k < HALF) ? coef_t'(v) : coef_t'(-v);
   endfunction

   coef_t sin_tab [N];
   for (genvar g = 0; g < N; g++) begin : g_tab
      assign sin_tab[g] = sin_val(g);
   end

   logic [FTW_W-1:0]  acc;
   logic [POW_W-1:0]  phase;
   logic [LUT_AW-1:0] idx_s, idx_c;

   assign acc_top = acc[FTW_W-1 -: POW_W];
   assign phase   = acc_top + pow;
   assign idx_s   = phase[POW_W-1 -: LUT_AW];
   assign idx_c   = idx_s + LUT_AW'(QUARTER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc   <= '0;
         cos_c <= '0;
         sin_c <= '0;
      end else begin
         acc   <= clr ? '0 : acc + ftw;
         cos_c <= sin_tab[idx_c];
         sin_c <= sin_tab[idx_s];
      end
   end
endmodule

// File: rtl/duc_mix.sv
module duc_mix #(
   parameter int DW       = 16,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [DW-1:0] in_i,
   input  logic signed [DW-1:0] in_q,
   input  logic signed [DW-1:0] cos_c,
   input  logic signed [DW-1:0] sin_c,
   input  logic                 sel,
   input  logic [DW-1:0]        test_i,
   input  logic [DW-1:0]        test_q,
   output logic [DW-1:0]        out_i,
   output logic [DW-1:0]        out_q
);
   localparam int PW = 2 * DW + 1;
   localparam logic signed [PW-1:0] MAXV = PW'((longint'(1) <<< (DW - 1)) - 1);
   localparam logic signed [PW-1:0] MINV = -PW'(longint'(1) <<< (DW - 1));

   logic signed [DW-1:0] s_i, s_q;
   logic signed [PW-1:0] bias, sum_i, sum_q, sh_i, sh_q;

   if (ROUND_EN) begin : g_round
      assign bias = {{(PW-DW+1){1'b0}}, 1'b1, {(DW-2){1'b0}}};
   end else begin : g_trunc
      assign bias = '0;
   end

   function automatic logic [DW-1:0] clip(input logic signed [PW-1:0] x);
      if (x > MAXV)      return MAXV[DW-1:0];
      else if (x < MINV) return MINV[DW-1:0];
      else               return x[DW-1:0];
   endfunction

   assign sum_i = PW'(s_i) * PW'(cos_c) - PW'(s_q) * PW'(sin_c);
   assign sum_q = PW'(s_i) * PW'(sin_c) + PW'(s_q) * PW'(cos_c);
   assign sh_i  = (sum_i + bias) >>> (DW - 1);
   assign sh_q  = (sum_q + bias) >>> (DW - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_i   <= '0;
         s_q   <= '0;
         out_i <= '0;
         out_q <= '0;
      end else begin
         s_i   <= in_i;
         s_q   <= in_q;
         out_i <= sel ? test_i : clip(sh_i);
         out_q <= sel ? test_q : clip(sh_q);
      end
   end
endmodule

// File: rtl/staged_duc.sv
module staged_duc
   import duc_pkg::*;
#(
   parameter int NPAIR    = 2,
   parameter int DW       = 16,
   parameter int FTW_W    = 32,
   parameter int POW_W    = 16,
   parameter int LUT_AW   = 8,
   parameter bit ROUND_EN = 1'b1,
   localparam int PAIR_W  = (NPAIR > 1) ? $clog2(NPAIR) : 1,
   localparam int WD      = (FTW_W > 2 * DW) ? FTW_W : 2 * DW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [PAIR_W-1:0]   wr_pair,
   input  logic [1:0]          wr_addr,
   input  logic [WD-1:0]       wr_data,
   input  logic                upd_stb,
   input  logic [NPAIR*DW-1:0] bb_i,
   input  logic [NPAIR*DW-1:0] bb_q,
   output logic [NPAIR*DW-1:0] dac_i,
   output logic [NPAIR*DW-1:0] dac_q
);
   if (NPAIR < 1 || DW < 4 || FTW_W < POW_W) begin : g_bad_cfg
      $error("staged_duc: invalid width or pair count");
   end

   logic [NPAIR-1:0]         act_hold_v, act_once_v, act_sel_v;
   logic [NPAIR*POW_W-1:0]   act_pow_v, acc_top_v;
   logic [NPAIR*2*DW-1:0]    test_v;

   for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      logic [FTW_W-1:0]     ftw;
      logic [POW_W-1:0]     pow;
      duc_ctrl_t            ctrl;
      logic [DW-1:0]        t_i, t_q;
      logic signed [DW-1:0] c_cos, c_sin;
      logic                 lane_wr;

      assign lane_wr = wr_en && (wr_pair == PAIR_W'(k));

      duc_regs #(.FTW_W(FTW_W), .POW_W(POW_W), .DW(DW), .WD(WD)) u_regs (
         .clk(clk), .rst_n(rst_n), .wr_en(lane_wr),
         .wr_addr(duc_reg_e'(wr_addr)), .wr_data(wr_data), .upd_stb(upd_stb),
         .act_ftw(ftw), .act_pow(pow), .act_ctrl(ctrl),
         .test_i(t_i), .test_q(t_q)
      );

      duc_nco #(.FTW_W(FTW_W), .POW_W(POW_W), .DW(DW), .LUT_AW(LUT_AW)) u_nco (
         .clk(clk), .rst_n(rst_n), .ftw(ftw), .pow(pow),
         .clr(ctrl.hold | ctrl.once),
         .acc_top(acc_top_v[k*POW_W +: POW_W]),
         .cos_c(c_cos), .sin_c(c_sin)
      );

      duc_mix #(.DW(DW), .ROUND_EN(ROUND_EN)) u_mix (
         .clk(clk), .rst_n(rst_n),
         .in_i(bb_i[k*DW +: DW]), .in_q(bb_q[k*DW +: DW]),
         .cos_c(c_cos), .sin_c(c_sin), .sel(ctrl.sel),
         .test_i(t_i), .test_q(t_q),
         .out_i(dac_i[k*DW +: DW]), .out_q(dac_q[k*DW +: DW])
      );

      assign act_hold_v[k]                = ctrl.hold;
      assign act_once_v[k]                = ctrl.once;
      assign act_sel_v[k]                 = ctrl.sel;
      assign act_pow_v[k*POW_W +: POW_W]  = pow;
      assign test_v[k*2*DW +: 2*DW]       = {t_i, t_q};
   end
endmodule

// File: rtl/staged_duc_chk.sv
module staged_duc_chk #(
   parameter int NPAIR = 2,
   parameter int DW    = 16,
   parameter int POW_W = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   upd_stb,
   input logic [NPAIR*DW-1:0]    dac_i,
   input logic [NPAIR*DW-1:0]    dac_q,
   input logic [NPAIR-1:0]       act_hold_v,
   input logic [NPAIR-1:0]       act_once_v,
   input logic [NPAIR-1:0]       act_sel_v,
   input logic [NPAIR*POW_W-1:0] act_pow_v,
   input logic [NPAIR*POW_W-1:0] acc_top_v,
   input logic [NPAIR*2*DW-1:0]  test_v
);
   p_reset_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dac_i == '0 && dac_q == '0));

   p_stage_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_stb |=> $stable(act_pow_v));

   p_once_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_stb |=> (act_once_v == '0));

   for (genvar k = 0; k < NPAIR; k++) begin : g_chk
      p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
         act_hold_v[k] |=> (acc_top_v[k*POW_W +: POW_W] == '0));

      p_test_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
         act_sel_v[k] |=> (dac_i[k*DW +: DW] == $past(test_v[k*2*DW+DW +: DW]) &&
                           dac_q[k*DW +: DW] == $past(test_v[k*2*DW +: DW])));
   end
endmodule

bind staged_duc staged_duc_chk #(.NPAIR(NPAIR), .DW(DW), .POW_W(POW_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb),
   .dac_i(dac_i), .dac_q(dac_q),
   .act_hold_v(act_hold_v), .act_once_v(act_once_v), .act_sel_v(act_sel_v),
   .act_pow_v(act_pow_v), .acc_top_v(acc_top_v), .test_v(test_v)
);

// File: tb/sim_staged_duc.sv
module sim_staged_duc;
   localparam int NP = 2;
   localparam int W  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [0:0]    wr_pair = '0;
   logic [1:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic          upd_stb = 1'b0;
   logic [NP*W-1:0] bb_i = '0, bb_q = '0;
   logic [NP*W-1:0] dac_i, dac_q;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   staged_duc u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pair(wr_pair),
      .wr_addr(wr_addr), .wr_data(wr_data), .upd_stb(upd_stb),
      .bb_i(bb_i), .bb_q(bb_q), .dac_i(dac_i), .dac_q(dac_q)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int p, input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_pair = 1'(p); wr_addr = 2'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk);
      upd_stb = 1'b1;
      @(negedge clk);
      upd_stb = 1'b0;
   endtask

   task automatic set_in(input int p, input int i, input int q);
      bb_i[p*W +: W] = W'(i);
      bb_q[p*W +: W] = W'(q);
   endtask

   function automatic int clip16(input longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return int'(v);
   endfunction

   // expected rotation at a quadrant phase: 0, 90, 180, 270 degrees
   task automatic exp_quad(input int i, input int q, input int quad,
                           output int ei, output int eq);
      longint c, s;
      case (quad & 3)
         0: begin c = 32767;  s = 0;      end
         1: begin c = 0;      s = 32767;  end
         2: begin c = -32767; s = 0;      end
         default: begin c = 0; s = -32767; end
      endcase
      ei = clip16((longint'(i) * c - longint'(q) * s + 16384) >>> 15);
      eq = clip16((longint'(i) * s + longint'(q) * c + 16384) >>> 15);
   endtask

   task automatic check(input string tag, input int p, input int ei, input int eq);
      int gi, gq;
      gi = int'($signed(dac_i[p*W +: W]));
      gq = int'($signed(dac_q[p*W +: W]));
      n_tests++;
      if (gi != ei || gq != eq) begin
         n_fail++;
         $display("FAIL %s pair%0d: got (%0d,%0d) expected (%0d,%0d)", tag, p, gi, gq, ei, eq);
      end
   endtask

   task automatic check_quad(input string tag, input int p, input int i, input int q, input int quad);
      int ei, eq;
      exp_quad(i, q, quad, ei, eq);
      check(tag, p, ei, eq);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      step(3);
      check("R1 in reset", 0, 0, 0);
      check("R1 in reset", 1, 0, 0);
      rst_n = 1'b1;
      set_in(0, 1000, 0);
      set_in(1, -2000, 500);
      // R12: two edges from input to output, phase zero after reset
      step(2);
      check_quad("R12 R7 latency phase0", 0, 1000, 0, 0);
      check_quad("R12 R7 latency phase0", 1, -2000, 500, 0);

      // R2 R3: staged writes have no effect before the strobe
      wr(0, 0, 32'h4000_0000);
      wr(0, 1, 32'h0000_8000);
      wr(1, 1, 32'h0000_4000);
      wr(1, 2, 32'h0000_0001);
      step(5);
      check_quad("R3 staged not applied", 0, 1000, 0, 0);
      check_quad("R3 staged not applied", 1, -2000, 500, 0);

      // R4 R5 R10: quarter-turn carrier with clear-once
      wr(0, 1, 32'h0);
      wr(0, 2, 32'h2);
      wr(1, 0, 32'h8000_0000);
      wr(1, 2, 32'h2);
      strobe();
      step(1);
      begin
         int q0 [6] = '{0, 0, 1, 2, 3, 0};
         int q1 [6] = '{1, 1, 3, 1, 3, 1};
         for (int k = 0; k < 6; k++) begin
            step(1);
            check_quad("R4 R5 R10 carrier sequence", 0, 1000, 0, q0[k]);
            check_quad("R4 R5 R10 carrier sequence", 1, -2000, 500, q1[k]);
         end
      end

      // R6 R9 R7: hold the accumulator, sweep offsets and inputs
      begin
         int pi [7] = '{1000, 0, -2000, 32767, -32768, 12345, -1};
         int pq [7] = '{0, 1000, 500, -32768, -32768, -321, 1};
         for (int quad = 0; quad < 4; quad++) begin
            wr(0, 0, 32'h1234_5678);
            wr(1, 0, 32'h0F0F_0F0F);
            wr(0, 1, 32'(quad * 32'h4000));
            wr(1, 1, 32'(((quad + 1) % 4) * 32'h4000));
            wr(0, 2, 32'h1);
            wr(1, 2, 32'h1);
            strobe();
            step(3);
            for (int t = 0; t < 7; t++) begin
               set_in(0, pi[t], pq[t]);
               set_in(1, pq[t], pi[t]);
               step(2);
               check_quad("R6 R9 R7 held phase sweep", 0, pi[t], pq[t], quad);
               check_quad("R6 R9 R7 held phase sweep", 1, pq[t], pi[t], (quad + 1) % 4);
            end
         end
      end

      // R8: saturation at 45 degrees
      wr(0, 1, 32'h0000_2000);
      wr(1, 1, 32'h0000_2000);
      strobe();
      step(3);
      set_in(0, 32767, 32767);
      set_in(1, 32767, 32767);
      step(2);
      check("R8 positive saturation", 0, 0, 32767);
      check("R8 positive saturation", 1, 0, 32767);
      set_in(0, -32768, -32768);
      set_in(1, -32768, -32768);
      step(2);
      check("R8 negative saturation", 0, 0, -32768);
      check("R8 negative saturation", 1, 0, -32768);

      // R11 R2: test word select, staged select, direct test word
      wr(0, 3, 32'h1234_ABCD);
      wr(1, 3, 32'h8000_7FFF);
      wr(0, 2, 32'h5);
      step(4);
      check("R3 select staged only", 0, 0, -32768);
      strobe();
      step(1);
      check("R11 R2 test word out", 0, 32'sh1234, -21555);
      check("R4 other pair still mixing", 1, 0, -32768);
      wr(0, 3, 32'h0001_FFFF);
      step(1);
      check("R11 direct test word", 0, 1, -1);
      wr(0, 2, 32'h1);
      strobe();
      step(1);
      check("R11 deselect back to mix", 0, 0, -32768);

      // R1: reset during operation clears outputs and settings
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 async reset", 0, 0, 0);
      check("R1 async reset", 1, 0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      set_in(0, 1000, 0);
      set_in(1, -2000, 500);
      step(2);
      check_quad("R1 settings cleared", 0, 1000, 0, 0);
      check_quad("R1 settings cleared", 1, -2000, 500, 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule